// File: doc/BRIEF.md
# Egress Port Steering Logic

This block sits between a single-input packet router's controller and its five egress FIFOs. When the controller marks a header byte, the block captures the destination port code from it and keeps that code for the rest of the packet. It routes the controller's single write strobe to the write enable of the chosen FIFO only. It returns that FIFO's full and empty flags to the controller as one selected pair. An unknown port code reports "full, not empty", so the controller stalls and never writes.

Each egress port's valid output is the inverse of its FIFO's empty flag. A per-port stall watchdog counts the cycles in which data waits and the receiver does not request a read. If the receiver stays silent for the whole allowed window, the watchdog raises a one-cycle flush pulse that clears that FIFO.

Top module: `egress_port_steer`

## Requirements
- R1: Reset is synchronous and active high. After reset the held port code is the all-ones code 7, which is invalid. Until the first header capture, every `wr_en` bit is 0, `sel_full` is 1 and `sel_empty` is 0. Every `flush` bit is 0 and every stall counter is cleared.
- R2: At a rising edge where `hdr_capture` is 1, the held port code takes the value of `hdr_field` (3 bits). It affects the outputs from the next cycle on. While `hdr_capture` is 0 the held code does not change, whatever `hdr_field` does.
- R3: When the held code n is a valid port (0 to 4), `sel_full` equals `fifo_full[n]` and `sel_empty` equals `fifo_empty[n]`. These outputs are combinational in the same cycle.
- R4: When the held code is 5, 6 or 7, `sel_full` is 1 and `sel_empty` is 0, whatever the FIFO flags are.
- R5: Bit n of `wr_en` equals `wr_strobe` for the port selected by the held code, and every other bit is 0. With an invalid code, all bits are 0.
- R6: `port_valid[n]` is the inverse of `fifo_empty[n]` in the same cycle, for every port, whatever the held code is.
- R7: A port is waiting when `port_valid[n]` is 1 and `rd_req[n]` is 0. After 30 consecutive waiting edges, `flush[n]` is 1 for exactly the one cycle that follows the 30th edge, and counting then starts again from zero.
- R8: An edge where `rd_req[n]` is 1 clears that port's count. A read request after 29 waiting edges therefore prevents the flush, and the next flush needs 30 new waiting edges.
- R9: An edge where `port_valid[n]` is 0 also clears that port's count.
- R10: The stall counters of different ports are independent. Activity on one port never changes when another port flushes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| hdr_capture | input | 1 | Marks the header cycle; the port code is captured at this edge |
| hdr_field | input | 3 | Destination port code taken from the header byte |
| wr_strobe | input | 1 | Write request from the router controller |
| fifo_full | input | 5 | Full flag of each egress FIFO |
| fifo_empty | input | 5 | Empty flag of each egress FIFO |
| rd_req | input | 5 | Read request from each egress receiver |
| sel_full | output | 1 | Full flag of the selected FIFO (1 for an invalid code) |
| sel_empty | output | 1 | Empty flag of the selected FIFO (0 for an invalid code) |
| wr_en | output | 5 | Write enable of each egress FIFO |
| port_valid | output | 5 | Data-available indication of each egress port |
| flush | output | 5 | One-cycle clear pulse of each egress FIFO after a receiver stall |

## Verification
The steering outputs (`sel_full`, `sel_empty`, `wr_en`, `port_valid`) are combinational from the inputs and the held code. A captured code is first seen one edge after the capture. The bench therefore drives flags and strobes at a falling edge and samples 1 ns later, after at least one edge has passed since the capture. The watchdog output is registered, so the flush pulse is due in the cycle after the 30th waiting edge. The bench counts rising edges explicitly from the falling edge where it starts a stall. It checks the flush output quiet just after edge 29 and set just after edge 30. A read or an idle gap resets that count, and the bench checks this the same way.

// File: rtl/steer_pkg.sv
package steer_pkg;

    // Selected FIFO status pair returned to the router controller
    typedef struct packed {
        logic full;
        logic empty;
    } fifo_flags_t;

    // Reported for an unmapped port code: stall the controller, never look ready
    localparam fifo_flags_t FLAGS_BLOCKED = '{full: 1'b1, empty: 1'b0};

    function automatic logic code_in_range(input int unsigned code,
                                           input int unsigned nports);
        return code < nports;
    endfunction

endpackage

// File: rtl/port_addr_latch.sv
module port_addr_latch #(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [ADDR_W-1:0] field_in,
    output logic [ADDR_W-1:0] code_q
);
    localparam logic [ADDR_W-1:0] IDLE_CODE = '1;

    always_ff @(posedge clk) begin
        if (rst)          code_q <= IDLE_CODE;
        else if (capture) code_q <= field_in;
    end

    // R2: code is held between header captures
    assert_code_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !capture |=> $stable(code_q));

    // R2: a capture loads the header field
    assert_code_load_R2: assert property (@(posedge clk) disable iff (rst)
        capture |=> code_q == $past(field_in));

endmodule

// File: rtl/flag_select.sv
module flag_select
    import steer_pkg::*;
#(
    parameter int NUM_PORTS = 5,
    parameter int ADDR_W    = 3
) (
    input  logic [ADDR_W-1:0]    code,
    input  logic [NUM_PORTS-1:0] full_vec,
    input  logic [NUM_PORTS-1:0] empty_vec,
    input  logic                 strobe,
    output fifo_flags_t          sel_flags,
    output logic [NUM_PORTS-1:0] wr_vec
);
    logic code_ok;

    always_comb begin
        code_ok   = code_in_range(int'(code), NUM_PORTS);
        sel_flags = FLAGS_BLOCKED;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (code_ok && code == ADDR_W'(p)) begin
                sel_flags.full  = full_vec[p];
                sel_flags.empty = empty_vec[p];
            end
        end
    end

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_wr_decode
        assign wr_vec[g] = strobe && (code == ADDR_W'(g));
    end

endmodule

// File: rtl/stall_watchdog.sv
module stall_watchdog #(
    parameter int STALL_LIMIT = 30
) (
    input  logic clk,
    input  logic rst,
    input  logic valid,
    input  logic rd,
    output logic flush
);
    localparam int CNT_W = $clog2(STALL_LIMIT + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(STALL_LIMIT - 1);

    logic [CNT_W-1:0] cnt;
    logic             waiting;

    assign waiting = valid && !rd;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            flush <= 1'b0;
        end else if (!waiting) begin
            cnt   <= '0;
            flush <= 1'b0;
        end else if (cnt == LAST) begin
            cnt   <= '0;
            flush <= 1'b1;
        end else begin
            cnt   <= cnt + 1'b1;
            flush <= 1'b0;
        end
    end

    // R7: flush is a single-cycle pulse
    assert_flush_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        flush |=> !flush);

    // R8: a read request cancels any pending flush
    assert_read_cancels_R8: assert property (@(posedge clk) disable iff (rst)
        rd |=> !flush);

    // R9: an idle (empty) port never flushes on the next cycle
    assert_idle_cancels_R9: assert property (@(posedge clk) disable iff (rst)
        !valid |=> !flush);

endmodule

// File: rtl/egress_port_steer.sv
module egress_port_steer
    import steer_pkg::*;
#(
    parameter int NUM_PORTS   = 5,
    parameter int ADDR_W      = 3,
    parameter int STALL_LIMIT = 30
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 hdr_capture,
    input  logic [ADDR_W-1:0]    hdr_field,
    input  logic                 wr_strobe,
    input  logic [NUM_PORTS-1:0] fifo_full,
    input  logic [NUM_PORTS-1:0] fifo_empty,
    input  logic [NUM_PORTS-1:0] rd_req,
    output logic                 sel_full,
    output logic                 sel_empty,
    output logic [NUM_PORTS-1:0] wr_en,
    output logic [NUM_PORTS-1:0] port_valid,
    output logic [NUM_PORTS-1:0] flush
);
    logic [ADDR_W-1:0] code_q;
    fifo_flags_t       sel_flags;

    port_addr_latch #(.ADDR_W(ADDR_W)) u_latch (
        .clk      (clk),
        .rst      (rst),
        .capture  (hdr_capture),
        .field_in (hdr_field),
        .code_q   (code_q)
    );

    flag_select #(.NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W)) u_select (
        .code      (code_q),
        .full_vec  (fifo_full),
        .empty_vec (fifo_empty),
        .strobe    (wr_strobe),
        .sel_flags (sel_flags),
        .wr_vec    (wr_en)
    );

    assign sel_full   = sel_flags.full;
    assign sel_empty  = sel_flags.empty;
    assign port_valid = ~fifo_empty;

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
        stall_watchdog #(.STALL_LIMIT(STALL_LIMIT)) u_wdog (
            .clk   (clk),
            .rst   (rst),
            .valid (port_valid[g]),
            .rd    (rd_req[g]),
            .flush (flush[g])
        );
    end

    // R5: at most one FIFO is written per cycle
    assert_wr_onehot_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_en));

    // R5: no write enable without the controller strobe
    assert_wr_needs_strobe_R5: assert property (@(posedge clk) disable iff (rst)
        !wr_strobe |-> wr_en == '0);

    // R4: a write can only happen when the selected FIFO reports not full or a valid port exists
    assert_blocked_no_write_R4: assert property (@(posedge clk) disable iff (rst)
        (sel_full && !sel_empty && fifo_full == '0) |-> wr_en == '0);

endmodule

// File: tb/egress_port_steer_bench.sv
module egress_port_steer_bench;
    localparam int NP = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          hdr_capture = 1'b0;
    logic [2:0]    hdr_field = '0;
    logic          wr_strobe = 1'b0;
    logic [NP-1:0] fifo_full = '0;
    logic [NP-1:0] fifo_empty = '1;
    logic [NP-1:0] rd_req = '0;
    logic          sel_full, sel_empty;
    logic [NP-1:0] wr_en, port_valid, flush;

    int total = 0;
    int failed = 0;

    always #10 clk = ~clk;

    egress_port_steer u_egress_port_steer (
        .clk(clk), .rst(rst), .hdr_capture(hdr_capture), .hdr_field(hdr_field),
        .wr_strobe(wr_strobe), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
        .rd_req(rd_req), .sel_full(sel_full), .sel_empty(sel_empty),
        .wr_en(wr_en), .port_valid(port_valid), .flush(flush)
    );

    // {code[3], full[5], empty[5], strobe, exp_full, exp_empty, exp_wr[5]}
    localparam int NV = 8;
    localparam logic [20:0] VEC [NV] = '{
        {3'd0, 5'b00001, 5'b00000, 1'b1, 1'b1, 1'b0, 5'b00001},
        {3'd1, 5'b00000, 5'b00010, 1'b1, 1'b0, 1'b1, 5'b00010},
        {3'd2, 5'b11011, 5'b00100, 1'b0, 1'b0, 1'b1, 5'b00000},
        {3'd3, 5'b01000, 5'b10111, 1'b1, 1'b1, 1'b0, 5'b01000},
        {3'd4, 5'b01111, 5'b10000, 1'b1, 1'b0, 1'b1, 5'b10000},
        {3'd5, 5'b00000, 5'b11111, 1'b1, 1'b1, 1'b0, 5'b00000},
        {3'd7, 5'b00000, 5'b11111, 1'b1, 1'b1, 1'b0, 5'b00000},
        {3'd4, 5'b10000, 5'b00000, 1'b0, 1'b1, 1'b0, 5'b00000}
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic quiet_ports();
        @(negedge clk);
        fifo_empty = '1;
        rd_req     = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #4_000_000;
        total++;
        failed++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        wr_strobe  = 1'b1;
        fifo_full  = '0;
        fifo_empty = '0;
        #1;
        chk("R1 wr_en after reset", {3'b0, wr_en}, 8'h00);
        chk("R1 sel_full after reset", {7'b0, sel_full}, 8'h01);
        chk("R1 sel_empty after reset", {7'b0, sel_empty}, 8'h00);
        chk("R1 flush after reset", {3'b0, flush}, 8'h00);
        wr_strobe = 1'b0;
        quiet_ports();

        // R3 R4 R5 R6: vector table
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            hdr_capture = 1'b1;
            hdr_field   = VEC[i][20:18];
            wr_strobe   = 1'b0;
            @(posedge clk);
            @(negedge clk);
            hdr_capture = 1'b0;
            fifo_full   = VEC[i][17:13];
            fifo_empty  = VEC[i][12:8];
            wr_strobe   = VEC[i][7];
            #1;
            chk("R3/R4 sel_full", {7'b0, sel_full}, {7'b0, VEC[i][6]});
            chk("R3/R4 sel_empty", {7'b0, sel_empty}, {7'b0, VEC[i][5]});
            chk("R5 wr_en", {3'b0, wr_en}, {3'b0, VEC[i][4:0]});
            chk("R6 port_valid", {3'b0, port_valid}, {3'b0, ~VEC[i][12:8]});
        end

        // R2: capture timing and hold (held code is 4 here)
        @(negedge clk);
        fifo_full   = '0;
        fifo_empty  = '1;
        hdr_capture = 1'b1;
        hdr_field   = 3'd2;
        wr_strobe   = 1'b1;
        #1;
        chk("R2 old code before edge", {3'b0, wr_en}, 8'b00010000);
        @(posedge clk);
        @(negedge clk);
        hdr_capture = 1'b0;
        hdr_field   = 3'd0;
        #1;
        chk("R2 new code after edge", {3'b0, wr_en}, 8'b00000100);
        @(posedge clk);
        @(negedge clk);
        hdr_field = 3'd1;
        #1;
        chk("R2 code held without capture", {3'b0, wr_en}, 8'b00000100);
        wr_strobe = 1'b0;
        quiet_ports();

        // R7: stall on port 1
        fifo_empty = 5'b11101;
        repeat (29) @(posedge clk);
        #1 chk("R7 no flush after 29 edges", {3'b0, flush}, 8'h00);
        @(posedge clk);
        #1 chk("R7 flush after 30 edges", {3'b0, flush}, 8'b00000010);
        @(posedge clk);
        #1 chk("R7 flush lasts one cycle", {3'b0, flush}, 8'h00);
        quiet_ports();

        // R8: read request on port 2 restarts the window
        fifo_empty = 5'b11011;
        repeat (29) @(posedge clk);
        @(negedge clk);
        rd_req = 5'b00100;
        @(posedge clk);
        #1 chk("R8 read prevents flush", {3'b0, flush}, 8'h00);
        @(negedge clk);
        rd_req = '0;
        repeat (29) @(posedge clk);
        #1 chk("R8 no flush 29 edges after read", {3'b0, flush}, 8'h00);
        @(posedge clk);
        #1 chk("R8 flush 30 edges after read", {3'b0, flush}, 8'b00000100);
        quiet_ports();

        // R9 R10: ports 0 and 3 stall together, port 3 goes empty once
        fifo_empty = 5'b10110;
        repeat (20) @(posedge clk);
        @(negedge clk);
        fifo_empty[3] = 1'b1;
        @(posedge clk);
        @(negedge clk);
        fifo_empty[3] = 1'b0;
        repeat (8) @(posedge clk);
        #1 chk("R10 no flush at edge 29", {3'b0, flush}, 8'h00);
        @(posedge clk);
        #1 chk("R10 only port 0 flushes at edge 30", {3'b0, flush}, 8'b00000001);
        repeat (20) @(posedge clk);
        #1 chk("R9 port 3 quiet at edge 50", {3'b0, flush}, 8'h00);
        @(posedge clk);
        #1 chk("R9 port 3 flushes at edge 51", {3'b0, flush}, 8'b00001000);

        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end
endmodule